// File: doc/BRIEF.md
# Multichannel Low-Side Driver Mode Controller

This block keeps the operating mode of twelve low-side output channels and sequences them from a parallel copy of a 32-bit serial command word. Each channel reads a 2-bit command from its own field of that word. The command can turn the channel on, turn it off with the open-load diagnostic current running, put it in standby with the diagnostic current stopped, or leave it as it is. The block drives one gate-enable and one diagnostic-current enable per channel.

An overload input per channel latches that channel off. The latch holds until a standby command reaches the same channel. The latched faults, the stored command word and a transmission-error flag are brought out for the serial status logic, which packs the 33-bit status frame outside this block.

Power-on reset and a low enable level both put the block in its quiet power-up state. In that state every command bit reads 1 and every channel is off with no diagnostic current. An explicit off command later switches the diagnostic current on.

Top module: `lsd_mode_ctrl`

## Requirements
- R1: Channel n takes its command from frame bits [2n+1:2n], and only in a cycle where the load strobe is high. Frame bits [31:24] reach no channel, but they are stored in the command word output like the other bits.
- R2: Command 2'b10 on a channel with no latched fault sets its gate output to 1 and its diagnostic output to 0 after the loading clock edge.
- R3: Command 2'b11 sets the gate to 0 and the diagnostic output to 1 after the loading edge, whatever state the channel was in before.
- R4: Command 2'b00 sets the gate and diagnostic outputs to 0 and clears that channel's latched fault. Faults on other channels are left as they were.
- R5: Command 2'b01 leaves the channel's gate and diagnostic outputs unchanged.
- R6: An overload input that is high at a clock edge while that channel's gate is 1 sets the channel's fault bit, and the gate is 0 after that edge. The fault stays set, and the gate stays 0 even after further 2'b10 commands, until a 2'b00 command arrives. An overload on a channel whose gate is 0 latches nothing.
- R7: While reset is low, every gate and diagnostic output is 0 in the same cycle. After a reset edge the command word output is all ones, the diagnostic outputs are 0, the fault vector is 0 and the transmission-error flag is 1.
- R8: While enable is low, all gate and diagnostic outputs are 0 at once, loads are ignored, and the state returns to the post-reset values of R7. Those values persist after enable rises.
- R9: The transmission-error flag becomes 0 after the first load edge and stays 0 until the next reset or low enable.
- R10: With the load strobe low, changes on the frame input alter neither the command word output nor any channel output.
- R11: Each channel acts only on its own field and its own overload input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous state reset; masks outputs at once |
| en_i | input | 1 | Enable; low forces the sleep/cleared state |
| load_i | input | 1 | One-cycle strobe marking a complete valid frame |
| frame_i | input | 32 | Parallel copy of the serial command word |
| ovl_i | input | 12 | Per-channel overload indication |
| gate_o | output | 12 | Per-channel output-transistor enable |
| diag_o | output | 12 | Per-channel open-load diagnostic-current enable |
| fault_o | output | 12 | Per-channel latched overload fault |
| cmd_o | output | 32 | Stored command word |
| xfer_err_o | output | 1 | Transmission-error flag, 1 until the first valid frame |

## Verification
The hardest case to reach is a channel that is on and latched off, then commanded on again, then cleared. It has to be shown that only a standby command releases the latch, and that clearing one channel leaves a second faulted channel alone. The stimulus first turns every channel on and then overloads two of them together with one channel in standby. It then sends a repeated on command, a standby to only one of the faulted channels, and finally a fresh on command. A second rare case is an on command arriving in the same cycle as an overload on a channel that is already on. The fault must still latch there.

// File: rtl/lsd_pkg.sv
// Package: shared command codes and channel mode encoding for the
// low-side driver mode controller.
// Assumes: 2-bit command fields; codes are fixed by the serial protocol.
package lsd_pkg;

    typedef enum logic [1:0] {
        CMD_STBY = 2'b00,
        CMD_HOLD = 2'b01,
        CMD_ON   = 2'b10,
        CMD_OFF  = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        M_PUOFF = 2'd0,  // off, diagnostic current disabled (power-up form)
        M_OFF   = 2'd1,  // off, diagnostic current enabled
        M_ON    = 2'd2,  // output driven
        M_STBY  = 2'd3   // off, diagnostic current disabled
    } chan_mode_e;

endpackage

// File: rtl/lsd_cmd_reg.sv
// Module: lsd_cmd_reg
// Holds the parallel copy of the serial command word and the
// transmission-error flag.
// Assumes: load_i is a single-cycle strobe issued once per valid frame;
// rst_n is synchronous and active low; en_i low acts as a full clear.
module lsd_cmd_reg #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic [FRAME_W-1:0] cmd_q,
    output logic               xfer_err_o
);

    localparam logic [FRAME_W-1:0] CMD_RST = {FRAME_W{1'b1}};

    logic alive;
    assign alive = rst_n & en_i;

    // Capture the command word on a frame strobe; all ones after clear.
    always_ff @(posedge clk) begin
        if (!alive)
            cmd_q <= CMD_RST;
        else if (load_i)
            cmd_q <= frame_i;
    end

    // Error flag: set by clear, dropped by the first valid frame.
    always_ff @(posedge clk) begin
        if (!alive)
            xfer_err_o <= 1'b1;
        else if (load_i)
            xfer_err_o <= 1'b0;
    end

    // R9: a valid frame removes the error flag.
    p_err_clears_r9: assert property (@(posedge clk) disable iff (!alive)
        load_i |=> !xfer_err_o);

    // R10: the word is held when no frame arrives.
    p_word_held_r10: assert property (@(posedge clk) disable iff (!alive)
        !load_i |=> $stable(cmd_q));

    // R7: after a clear the word reads all ones.
    p_clear_ones_r7: assert property (@(posedge clk)
        !alive |=> (cmd_q == CMD_RST) && xfer_err_o);

endmodule

// File: rtl/lsd_chan.sv
// Module: lsd_chan
// One channel: mode sequencing from a 2-bit command and an overload latch
// that forces the gate off until a standby command clears it.
// Assumes: cmd_i is valid whenever load_i is high; ovl_i is already
// synchronous to clk; rst_n and en_i also mask the outputs combinationally.
module lsd_chan
    import lsd_pkg::*;
#(
    parameter int CMD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             load_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             ovl_i,
    output logic             gate_o,
    output logic             diag_o,
    output logic             fault_o
);

    chan_mode_e mode_q;
    logic       fault_q;
    logic       alive;
    logic       stby_cmd;

    assign alive    = rst_n & en_i;
    assign stby_cmd = load_i && (cmd_i == CMD_STBY);

    // Mode update: apply the loaded command, return to power-up off on clear.
    always_ff @(posedge clk) begin
        if (!alive) begin
            mode_q <= M_PUOFF;
        end else if (load_i) begin
            case (cmd_e'(cmd_i))
                CMD_STBY: mode_q <= M_STBY;
                CMD_ON:   mode_q <= M_ON;
                CMD_OFF:  mode_q <= M_OFF;
                default:  mode_q <= mode_q;
            endcase
        end
    end

    // Overload latch: set while driven, cleared only by standby or clear.
    always_ff @(posedge clk) begin
        if (!alive)
            fault_q <= 1'b0;
        else if (stby_cmd)
            fault_q <= 1'b0;
        else if (ovl_i && gate_o)
            fault_q <= 1'b1;
    end

    // Output decode: masked at once by reset or a low enable.
    always_comb begin
        gate_o  = alive && (mode_q == M_ON) && !fault_q;
        diag_o  = alive && (mode_q == M_OFF);
        fault_o = fault_q;
    end

    // R2: an on command drives the gate when no fault is pending.
    p_on_drives_r2: assert property (@(posedge clk) disable iff (!alive)
        (load_i && cmd_i == CMD_ON && !fault_q && !(ovl_i && gate_o))
        |=> gate_o && !diag_o);

    // R3: an off command enables diagnostics with the gate off.
    p_off_diag_r3: assert property (@(posedge clk) disable iff (!alive)
        (load_i && cmd_i == CMD_OFF) |=> diag_o && !gate_o);

    // R4: standby is quiet and fault-free.
    p_stby_clear_r4: assert property (@(posedge clk) disable iff (!alive)
        stby_cmd |=> !diag_o && !gate_o && !fault_o);

    // R5: hold leaves the outputs as they were.
    p_hold_keeps_r5: assert property (@(posedge clk) disable iff (!alive)
        (load_i && cmd_i == CMD_HOLD && !ovl_i) |=> $stable(gate_o) && $stable(diag_o));

    // R6: a fault only appears after an overload while driven.
    p_fault_cause_r6: assert property (@(posedge clk) disable iff (!alive)
        $rose(fault_q) |-> $past(ovl_i && gate_o));

    // R6: the fault persists until a standby command.
    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!alive)
        (fault_q && !stby_cmd) |=> fault_q && !gate_o);

endmodule

// File: rtl/lsd_mode_ctrl.sv
// Module: lsd_mode_ctrl (top)
// Twelve-channel low-side driver mode controller: stores the command word,
// fans its 2-bit fields out to one channel controller each, and collects
// gate, diagnostic and latched-fault vectors.
// Assumes: the frame is fully shifted in when load_i pulses; reserved
// upper frame bits are stored but drive no channel.
module lsd_mode_ctrl
    import lsd_pkg::*;
#(
    parameter int NUM_CH  = 12,
    parameter int CMD_W   = 2,
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [NUM_CH-1:0]  ovl_i,
    output logic [NUM_CH-1:0]  gate_o,
    output logic [NUM_CH-1:0]  diag_o,
    output logic [NUM_CH-1:0]  fault_o,
    output logic [FRAME_W-1:0] cmd_o,
    output logic               xfer_err_o
);

    localparam int FIELD_BITS = NUM_CH * CMD_W;

    // Command word and frame-integrity flag.
    lsd_cmd_reg #(.FRAME_W(FRAME_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .load_i     (load_i),
        .frame_i    (frame_i),
        .cmd_q      (cmd_o),
        .xfer_err_o (xfer_err_o)
    );

    // One controller per channel, each on its own field of the frame.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        lsd_chan #(.CMD_W(CMD_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_i),
            .load_i  (load_i),
            .cmd_i   (frame_i[n*CMD_W +: CMD_W]),
            .ovl_i   (ovl_i[n]),
            .gate_o  (gate_o[n]),
            .diag_o  (diag_o[n]),
            .fault_o (fault_o[n])
        );
    end

    // R7/R8: reset or a low enable silences every output at once.
    always_comb begin
        if (!rst_n || !en_i)
            p_quiet_r7: assert ((gate_o == '0) && (diag_o == '0));
    end

    // R1: the field layout must fit below the reserved bits.
    initial begin
        p_layout_r1: assert (FIELD_BITS <= FRAME_W);
    end

endmodule

// File: tb/lsd_mode_ctrl_test.sv
// Scoreboard bench: the driver task drives one cycle and pushes the
// expected outputs from a requirement-level model; the monitor pops and
// compares just after each rising edge.
module lsd_mode_ctrl_test;

    localparam int NCH = 12;
    localparam int FW  = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en_i = 1'b0;
    logic           load_i = 1'b0;
    logic [FW-1:0]  frame_i = '0;
    logic [NCH-1:0] ovl_i = '0;
    logic [NCH-1:0] gate_o, diag_o, fault_o;
    logic [FW-1:0]  cmd_o;
    logic           xfer_err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    lsd_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .load_i(load_i),
        .frame_i(frame_i), .ovl_i(ovl_i), .gate_o(gate_o), .diag_o(diag_o),
        .fault_o(fault_o), .cmd_o(cmd_o), .xfer_err_o(xfer_err_o)
    );

    typedef struct {
        logic [NCH-1:0] g, d, f;
        logic [FW-1:0]  c;
        logic           x;
        string          tag;
    } exp_t;

    exp_t q[$];

    // Reference model state (0 pwr-off, 1 off+diag, 2 on, 3 standby).
    int             m_mode[NCH];
    logic [NCH-1:0] m_flt;
    logic [FW-1:0]  m_cmd;
    logic           m_x;

    function automatic logic [NCH-1:0] m_gate(input logic live);
        logic [NCH-1:0] v;
        for (int n = 0; n < NCH; n++) v[n] = live && m_mode[n] == 2 && !m_flt[n];
        return v;
    endfunction

    function automatic logic [NCH-1:0] m_diag(input logic live);
        logic [NCH-1:0] v;
        for (int n = 0; n < NCH; n++) v[n] = live && m_mode[n] == 1;
        return v;
    endfunction

    task automatic step(input logic r, input logic e, input logic ld,
                        input logic [FW-1:0] fr, input logic [NCH-1:0] ov,
                        input string tag);
        exp_t           it;
        logic [NCH-1:0] pre_g;
        @(negedge clk);
        rst_n = r; en_i = e; load_i = ld; frame_i = fr; ovl_i = ov;
        pre_g = m_gate(r && e);
        if (!r || !e) begin
            #1;
            checks++;
            if (gate_o !== '0 || diag_o !== '0) begin
                fails++;
                $display("FAIL %s immediate off: gate=%h diag=%h expected 000 000", tag, gate_o, diag_o);
            end
            for (int n = 0; n < NCH; n++) m_mode[n] = 0;
            m_flt = '0; m_cmd = '1; m_x = 1'b1;
        end else begin
            for (int n = 0; n < NCH; n++) begin
                logic [1:0] c;
                c = fr[2*n +: 2];
                if (ld) begin
                    case (c)
                        2'b00: begin m_mode[n] = 3; m_flt[n] = 1'b0; end
                        2'b10: m_mode[n] = 2;
                        2'b11: m_mode[n] = 1;
                        default: ;
                    endcase
                end
                if (!(ld && c == 2'b00) && ov[n] && pre_g[n]) m_flt[n] = 1'b1;
            end
            if (ld) begin m_cmd = fr; m_x = 1'b0; end
        end
        it.g = m_gate(r && e); it.d = m_diag(r && e); it.f = m_flt;
        it.c = m_cmd; it.x = m_x; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare right after each rising edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            checks++;
            if (gate_o !== it.g || diag_o !== it.d || fault_o !== it.f ||
                cmd_o !== it.c || xfer_err_o !== it.x) begin
                fails++;
                $display("FAIL %s: got g=%h d=%h f=%h c=%h x=%b expected g=%h d=%h f=%h c=%h x=%b",
                         it.tag, gate_o, diag_o, fault_o, cmd_o, xfer_err_o,
                         it.g, it.d, it.f, it.c, it.x);
            end
        end
    end

    initial begin
        for (int n = 0; n < NCH; n++) m_mode[n] = 0;
        m_flt = '0; m_cmd = '1; m_x = 1'b1;

        step(0, 1, 0, '0, '0, "R7 reset");
        step(0, 1, 1, 32'h00AAAAAA, '0, "R7 reset ignores load");
        step(1, 1, 0, '0, '0, "R7 power-up off no diag");
        step(1, 1, 0, 32'h12345678, 12'hFFF, "R10 frame without load");
        step(1, 1, 1, 32'h00AAAAAA, '0, "R2 R9 all on");
        step(1, 1, 0, '0, '0, "R9 flag stays low");
        step(1, 1, 1, 32'h5A5555E4, '0, "R1 R3 R4 R5 R11 mixed");
        step(1, 1, 0, '0, 12'h025, "R6 overload latch and standby immune");
        step(1, 1, 1, 32'h00555565, '0, "R6 on while faulted stays off");
        step(1, 1, 1, 32'h00555545, '0, "R4 standby clears only own fault");
        step(1, 1, 1, 32'h00555565, '0, "R2 on after clear");
        step(1, 1, 1, 32'hFF555555, '0, "R1 reserved bits ignored");
        step(1, 1, 1, 32'h0055556A, 12'h004, "R6 overload with on load");
        step(1, 0, 1, 32'h00AAAAAA, '0, "R8 enable low clears");
        step(1, 0, 0, '0, '0, "R8 sleep");
        step(1, 1, 0, '0, '0, "R8 wake to power-up off");
        step(1, 1, 1, 32'h00FFFFFF, '0, "R3 explicit off enables diag");
        step(1, 1, 1, 32'h00FFFFF6, 12'hFFF, "R5 R6 hold and off ignore overload");
        step(0, 1, 0, '0, '0, "R7 reset from running");
        step(1, 1, 0, '0, '0, "R7 after reset");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule